// File: doc/BRIEF.md
# Match-Capture Timer with Single-Edge PWM

This block is a general-purpose timer built around one up-counter. The counter advances on a count tick. A tick comes either from a programmable divider on the block clock or from a chosen edge of one of the capture pins. Each of several compare channels watches the count. When a channel's value is reached, the channel sets a sticky event flag and applies a programmed action to its output pin. Each capture pin passes through a synchronizer and an edge detector. A selected transition copies the count into that pin's capture register and sets a flag. One interrupt line combines every flag whose enable bit is set.

In PWM mode the highest-numbered compare channel sets the period: the counter returns to zero on the tick after it equals that value. Every other channel then drives a single-edge waveform. That output is low at the start of each period and goes high once the count reaches the channel's compare value. Software reaches everything through a word-wide register port, where writes take effect at the clock edge and reads are combinational.

Top module: `mct_timer`

## Requirements
- R1: After reset the count, all compare and capture registers, all configuration fields and all flags read zero, `match_out` is all low and `irq` is low.
- R2: With the run bit (bit 0 at address 0) set and the count source at 00 (internal), the count advances by one every `divider+1` clock cycles, where `divider` is at address 1. With the run bit clear the count holds its value.
- R3: While the hold bit (bit 1 at address 0) is set, the count and the divider are forced to zero whatever the run bit is, so the first tick after release comes `divider+1` cycles later. The count reads at address 2.
- R4: On a tick where the next count equals compare value i (address 8+i), flag bit i at address 6 is set. Flags stay set until 1 is written to the bit, and writing 0 leaves a bit alone. `irq` is high when any flag is set whose enable is set: bit 16+i at address 4 for channel i, and bit 16+j at address 5 for capture pin j.
- R5: The 2-bit action of channel i sits at bits 2i+1:2i of address 4. On a match it sets the output as follows: 00 leaves it, 01 drives it low, 10 drives it high, 11 inverts it.
- R6: The edge select of capture pin j sits at bits 2j+1:2j of address 5: 00 off, 01 rising, 10 falling, 11 both. A selected edge, seen after a two-flop synchronizer, loads capture register j (address 16+j) with the count of the cycle in which the edge is detected. That is the count present two clock edges after the pin changes. The same event sets flag bit 16+j at address 6. Edges that are not selected change neither register nor flag.
- R7: A nonzero count-source field (bits 1:0 of address 3, coded as in R6) makes the count advance once per selected synchronized edge of the capture pin indexed by bits 4 and up of address 3. The divider is bypassed, and the other pins have no effect.
- R8: With PWM mode on (bit 24 of address 4), a tick taken while the count equals the last channel's compare value returns the count to zero.
- R9: In PWM mode the output of every channel except the last is high exactly when count >= its compare value. A compare value of zero therefore holds it high for the whole period, and a value above the period holds it low.
- R10: Compare registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| cap_in | input | N_CAP | Capture and external count pins |
| match_out | output | N_CMP | Compare channel outputs |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that the hold bit, the run bit and the compare registers change only through register writes. They also assume the count register is never written, so any count change must come from a tick, a hold or a PWM wrap. Capture pins are treated as asynchronous. The stimulus keeps each pin level for at least three clock cycles, so the synchronizer never merges two edges. It also configures the divider, the period and the duty values before it releases the hold bit, which keeps every counted window aligned with a freshly cleared divider.

// File: rtl/mct_pkg.sv
package mct_pkg;

   localparam int DATA_W = 32;

   // register addresses
   localparam int A_CTRL  = 0;
   localparam int A_DIV   = 1;
   localparam int A_COUNT = 2;
   localparam int A_SRC   = 3;
   localparam int A_MCFG  = 4;
   localparam int A_CCFG  = 5;
   localparam int A_FLAGS = 6;
   localparam int A_CMP0  = 8;
   localparam int A_CAP0  = 16;

   // field positions
   localparam int EN_BASE  = 16;
   localparam int PWM_BIT  = 24;
   localparam int PIN_BASE = 4;

   typedef enum logic [1:0] {
      ACT_KEEP   = 2'b00,
      ACT_LOW    = 2'b01,
      ACT_HIGH   = 2'b10,
      ACT_INVERT = 2'b11
   } act_e;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_e;

   function automatic logic edge_pick(edge_e sel, logic rise, logic fall);
      return ((sel == EDGE_RISE || sel == EDGE_BOTH) && rise) ||
             ((sel == EDGE_FALL || sel == EDGE_BOTH) && fall);
   endfunction

endpackage

// File: rtl/mct_edge_sync.sv
module mct_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mct_edge_sync: STAGES must be at least 2");
   end

   // STAGES synchronizer flops plus one history flop
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], pin};
   end

   assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
   assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];

endmodule

// File: rtl/mct_prescaler.sv
module mct_prescaler #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         hold,
   input  logic         bypass,
   input  logic         ext_edge,
   input  logic [W-1:0] limit,
   output logic         tick
);

   logic [W-1:0] div_q;
   logic         active;
   logic         wrap;

   assign active = run && !hold;
   assign wrap   = (div_q == limit);
   assign tick   = active && (bypass ? ext_edge : wrap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 div_q <= '0;
      else if (hold)              div_q <= '0;
      else if (active && !bypass) div_q <= wrap ? '0 : div_q + 1'b1;
   end

endmodule

// File: rtl/mct_match_unit.sv
module mct_match_unit
   import mct_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] count,
   input  logic [W-1:0] count_next,
   input  logic [W-1:0] cmp,
   input  act_e         action,
   input  logic         pwm_sel,
   output logic         hit,
   output logic         pin
);

   logic ext_q;

   assign hit = tick && (count_next == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_q <= 1'b0;
      else if (hit) begin
         unique case (action)
            ACT_KEEP:   ext_q <= ext_q;
            ACT_LOW:    ext_q <= 1'b0;
            ACT_HIGH:   ext_q <= 1'b1;
            ACT_INVERT: ext_q <= ~ext_q;
         endcase
      end
   end

   assign pin = pwm_sel ? (count >= cmp) : ext_q;

endmodule

// File: rtl/mct_timer.sv
module mct_timer
   import mct_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int N_CMP  = 4,
   parameter int N_CAP  = 2,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [N_CAP-1:0]  cap_in,
   output logic [N_CMP-1:0]  match_out,
   output logic              irq
);

   localparam int SEL_W = (N_CAP > 1) ? $clog2(N_CAP) : 1;
   localparam int LAST  = N_CMP - 1;

   if (CNT_W < 8 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("mct_timer: CNT_W must be within 8..32");
   end
   if (N_CMP < 2 || N_CMP > 8) begin : g_bad_cmp
      $error("mct_timer: N_CMP must be within 2..8");
   end
   if (N_CAP < 1 || N_CAP > 8) begin : g_bad_cap
      $error("mct_timer: N_CAP must be within 1..8");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("mct_timer: ADDR_W must be at least 5");
   end

   // configuration state
   logic             ctl_run, ctl_hold, pwm_mode;
   logic [CNT_W-1:0] div_q;
   edge_e            src_kind;
   logic [SEL_W-1:0] src_pin;
   act_e             act_q   [N_CMP];
   logic [N_CMP-1:0] mirq_en;
   edge_e            cedge   [N_CAP];
   logic [N_CAP-1:0] cirq_en;
   logic [CNT_W-1:0] cmp_q   [N_CMP];

   // run state
   logic [CNT_W-1:0] count_q, cnt_next;
   logic [CNT_W-1:0] cap_q   [N_CAP];
   logic [N_CMP-1:0] mflag, m_hit;
   logic [N_CAP-1:0] cflag, cap_hit, cap_rise, cap_fall;
   logic             tick, ext_edge, bypass, cnt_wrap, wr_flags;

   logic unused_bits;
   assign unused_bits = ^reg_wdata;

   assign wr_flags = reg_wr && (reg_addr == ADDR_W'(A_FLAGS));

   // register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_run  <= 1'b0;
         ctl_hold <= 1'b0;
         pwm_mode <= 1'b0;
         div_q    <= '0;
         src_kind <= EDGE_OFF;
         src_pin  <= '0;
         mirq_en  <= '0;
         cirq_en  <= '0;
         for (int i = 0; i < N_CMP; i++) begin
            act_q[i] <= ACT_KEEP;
            cmp_q[i] <= '0;
         end
         for (int j = 0; j < N_CAP; j++) cedge[j] <= EDGE_OFF;
      end else if (reg_wr) begin
         if (reg_addr == ADDR_W'(A_CTRL)) begin
            ctl_run  <= reg_wdata[0];
            ctl_hold <= reg_wdata[1];
         end
         if (reg_addr == ADDR_W'(A_DIV)) div_q <= reg_wdata[CNT_W-1:0];
         if (reg_addr == ADDR_W'(A_SRC)) begin
            src_kind <= edge_e'(reg_wdata[1:0]);
            src_pin  <= reg_wdata[PIN_BASE +: SEL_W];
         end
         if (reg_addr == ADDR_W'(A_MCFG)) begin
            for (int i = 0; i < N_CMP; i++) act_q[i] <= act_e'(reg_wdata[2*i +: 2]);
            mirq_en  <= reg_wdata[EN_BASE +: N_CMP];
            pwm_mode <= reg_wdata[PWM_BIT];
         end
         if (reg_addr == ADDR_W'(A_CCFG)) begin
            for (int j = 0; j < N_CAP; j++) cedge[j] <= edge_e'(reg_wdata[2*j +: 2]);
            cirq_en <= reg_wdata[EN_BASE +: N_CAP];
         end
         for (int i = 0; i < N_CMP; i++) begin
            if (reg_addr == ADDR_W'(A_CMP0 + i)) cmp_q[i] <= reg_wdata[CNT_W-1:0];
         end
      end
   end

   // capture pin conditioning and capture registers
   for (genvar j = 0; j < N_CAP; j++) begin : g_cap
      mct_edge_sync #(.STAGES(2)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .pin   (cap_in[j]),
         .rise  (cap_rise[j]),
         .fall  (cap_fall[j])
      );

      assign cap_hit[j] = edge_pick(cedge[j], cap_rise[j], cap_fall[j]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cap_q[j] <= '0;
         else if (cap_hit[j]) cap_q[j] <= count_q;
      end
   end

   // count source selection
   assign bypass = (src_kind != EDGE_OFF);

   always_comb begin
      ext_edge = 1'b0;
      for (int j = 0; j < N_CAP; j++) begin
         if (src_pin == SEL_W'(j)) ext_edge = edge_pick(src_kind, cap_rise[j], cap_fall[j]);
      end
   end

   mct_prescaler #(.W(CNT_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctl_run),
      .hold     (ctl_hold),
      .bypass   (bypass),
      .ext_edge (ext_edge),
      .limit    (div_q),
      .tick     (tick)
   );

   // counter
   assign cnt_wrap = pwm_mode && (count_q == cmp_q[LAST]);
   assign cnt_next = cnt_wrap ? '0 : count_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count_q <= '0;
      else if (ctl_hold) count_q <= '0;
      else if (tick)     count_q <= cnt_next;
   end

   // compare channels: the last one is the period channel
   for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
      logic duty_sel;
      if (i == LAST) begin : g_period
         assign duty_sel = 1'b0;
      end else begin : g_duty
         assign duty_sel = pwm_mode;
      end

      mct_match_unit #(.W(CNT_W)) u_unit (
         .clk        (clk),
         .rst_n      (rst_n),
         .tick       (tick),
         .count      (count_q),
         .count_next (cnt_next),
         .cmp        (cmp_q[i]),
         .action     (act_q[i]),
         .pwm_sel    (duty_sel),
         .hit        (m_hit[i]),
         .pin        (match_out[i])
      );
   end

   // sticky flags, write one to clear, set wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mflag <= '0;
         cflag <= '0;
      end else begin
         mflag <= (mflag & ~(wr_flags ? reg_wdata[N_CMP-1:0] : '0)) | m_hit;
         cflag <= (cflag & ~(wr_flags ? reg_wdata[EN_BASE +: N_CAP] : '0)) | cap_hit;
      end
   end

   assign irq = |(mflag & mirq_en) || |(cflag & cirq_en);

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(A_CTRL))  reg_rdata[1:0] = {ctl_hold, ctl_run};
      if (reg_addr == ADDR_W'(A_DIV))   reg_rdata[CNT_W-1:0] = div_q;
      if (reg_addr == ADDR_W'(A_COUNT)) reg_rdata[CNT_W-1:0] = count_q;
      if (reg_addr == ADDR_W'(A_SRC)) begin
         reg_rdata[1:0]                = src_kind;
         reg_rdata[PIN_BASE +: SEL_W]  = src_pin;
      end
      if (reg_addr == ADDR_W'(A_MCFG)) begin
         for (int i = 0; i < N_CMP; i++) reg_rdata[2*i +: 2] = act_q[i];
         reg_rdata[EN_BASE +: N_CMP] = mirq_en;
         reg_rdata[PWM_BIT]          = pwm_mode;
      end
      if (reg_addr == ADDR_W'(A_CCFG)) begin
         for (int j = 0; j < N_CAP; j++) reg_rdata[2*j +: 2] = cedge[j];
         reg_rdata[EN_BASE +: N_CAP] = cirq_en;
      end
      if (reg_addr == ADDR_W'(A_FLAGS)) begin
         reg_rdata[N_CMP-1:0]        = mflag;
         reg_rdata[EN_BASE +: N_CAP] = cflag;
      end
      for (int i = 0; i < N_CMP; i++) begin
         if (reg_addr == ADDR_W'(A_CMP0 + i)) reg_rdata[CNT_W-1:0] = cmp_q[i];
      end
      for (int j = 0; j < N_CAP; j++) begin
         if (reg_addr == ADDR_W'(A_CAP0 + j)) reg_rdata[CNT_W-1:0] = cap_q[j];
      end
   end

endmodule

// File: rtl/mct_timer_checker.sv
module mct_timer_checker
   import mct_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int N_CMP  = 4,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [CNT_W-1:0]  count,
   input logic              tick,
   input logic              hold,
   input logic              pwm_mode,
   input logic [CNT_W-1:0]  period,
   input logic [CNT_W-1:0]  duty0,
   input logic              duty0_pin,
   input logic [N_CMP-1:0]  mflags,
   input logic              cap0_hit,
   input logic [CNT_W-1:0]  cap0_val
);

   assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !hold && !(pwm_mode && count == period)) |=> (count == $past(count) + 1'b1));

   assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !hold) |=> $stable(count));

   assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (count == '0));

   assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == ADDR_W'(A_FLAGS)) |=> ((mflags & $past(mflags)) == $past(mflags)));

   assert_capture_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cap0_hit |=> (cap0_val == $past(count)));

   assert_pwm_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_mode && tick && !hold && count == period) |=> (count == '0));

   assert_pwm_zero_duty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_mode && duty0 == '0) |-> duty0_pin);

endmodule

bind mct_timer mct_timer_checker #(
   .CNT_W  (CNT_W),
   .N_CMP  (N_CMP),
   .ADDR_W (ADDR_W)
) u_mct_timer_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .count     (count_q),
   .tick      (tick),
   .hold      (ctl_hold),
   .pwm_mode  (pwm_mode),
   .period    (cmp_q[N_CMP-1]),
   .duty0     (cmp_q[0]),
   .duty0_pin (match_out[0]),
   .mflags    (mflag),
   .cap0_hit  (cap_hit[0]),
   .cap0_val  (cap_q[0])
);

// File: tb/mct_timer_bench.sv
module mct_timer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N_CMP = 4;
   localparam int N_CAP = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0;
   logic [4:0]       reg_addr = '0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;
   logic [N_CAP-1:0] cap_in = '0;
   logic [N_CMP-1:0] match_out;
   logic             irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mct_timer #(.CNT_W(32), .N_CMP(N_CMP), .N_CAP(N_CAP), .ADDR_W(5)) u_mct_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .cap_in    (cap_in),
      .match_out (match_out),
      .irq       (irq)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = 5'(a);
      #1;
      d = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulses(input int pin, input int n);
      for (int k = 0; k < n; k++) begin
         cap_in[pin] = 1'b1; cap_in[0] = ~cap_in[0] | (pin == 0 ? 1'b1 : 1'b0);
         idle(3);
         cap_in[pin] = 1'b0;
         idle(3);
      end
      idle(4);
   endtask

   function automatic int exp_div_count(int k, int div);
      return k / (div + 1);
   endfunction

   function automatic int exp_pwm_next(int c, int per);
      return (c == per) ? 0 : c + 1;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] d, v, c0;
      int unsigned seed_sink;
      seed_sink = $urandom(32'd7477);

      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(2, d);  chk("R1", "count", d, 0);
      rd(6, d);  chk("R1", "flags", d, 0);
      rd(0, d);  chk("R1", "ctrl", d, 0);
      rd(16, d); chk("R1", "capture0", d, 0);
      chk("R1", "match_out", 32'(match_out), 0);
      chk("R1", "irq", 32'(irq), 0);

      // R10 compare register readback
      wr(10, 32'hA5A5_5A5A);
      rd(10, d); chk("R10", "cmp2 readback", d, 32'hA5A5_5A5A);

      // R2 divider counting with random divisors
      for (int r = 0; r < 4; r++) begin
         int p, k;
         p = int'($urandom % 6);
         k = 10 + int'($urandom % 30);
         wr(1, 32'(p));
         wr(0, 2);
         wr(0, 1);
         idle(k);
         rd(2, d); chk("R2", "divided count", d, 32'(exp_div_count(k, p)));
      end
      wr(0, 0);
      rd(2, v);
      idle(7);
      rd(2, d); chk("R2", "count holds when stopped", d, v);

      // R3 hold clears count and divider
      wr(1, 2);
      wr(0, 1);
      idle(4);
      wr(0, 3);
      idle(3);
      rd(2, d); chk("R3", "count during hold", d, 0);
      wr(0, 1);
      idle(2);
      rd(2, d); chk("R3", "no tick before divider period", d, 0);
      idle(1);
      rd(2, d); chk("R3", "first tick after release", d, 1);

      // R4, R5 match flags, actions, interrupt
      begin
         int m;
         m = 3 + int'($urandom % 15);
         wr(0, 0);
         wr(1, 0);
         wr(8, 32'(m));
         wr(9, 32'(m + 2));
         wr(10, 32'(m + 1));
         wr(11, 32'(m));
         wr(4, 32'h0001_001B);  // ch0 invert, ch1 high, ch2 low, ch3 keep, irq on ch0
         wr(6, 32'hFFFF_FFFF);
         wr(0, 2);
         wr(0, 1);
         idle(m - 1);
         chk("R5", "ch0 before match", 32'(match_out[0]), 0);
         chk("R4", "irq before match", 32'(irq), 0);
         idle(1);
         chk("R5", "ch0 inverted on match", 32'(match_out[0]), 1);
         chk("R4", "irq on enabled match", 32'(irq), 1);
         chk("R5", "ch3 keep action", 32'(match_out[3]), 0);
         idle(2);
         chk("R5", "ch1 driven high", 32'(match_out[1]), 1);
         chk("R5", "ch2 driven low", 32'(match_out[2]), 0);
         rd(6, d); chk("R4", "all match flags", d, 32'hF);
         wr(6, 32'h1);
         rd(6, d); chk("R4", "write-one clears only bit0", d, 32'hE);
         chk("R4", "irq ignores disabled flags", 32'(irq), 0);
         rd(2, c0);
         wr(9, c0 + 6);
         wr(4, 32'h0001_0017);  // ch1 now drives low
         idle(8);
         chk("R5", "ch1 driven low", 32'(match_out[1]), 0);
      end

      // R6 capture with stopped counter
      wr(0, 0);
      wr(4, 0);
      rd(2, v);
      wr(6, 32'hFFFF_FFFF);
      wr(5, 32'h0001_0009);  // cap0 rising with irq, cap1 falling
      cap_in[0] = 1'b1;
      idle(4);
      rd(16, d); chk("R6", "cap0 on rising", d, v);
      rd(6, d);  chk("R6", "cap0 flag", d, 32'h0001_0000);
      chk("R4", "irq on capture", 32'(irq), 1);
      cap_in[1] = 1'b1;
      idle(4);
      rd(17, d); chk("R6", "cap1 ignores rising", d, 0);
      rd(6, d);  chk("R6", "cap1 flag clear after rising", d, 32'h0001_0000);
      cap_in[1] = 1'b0;
      idle(4);
      rd(17, d); chk("R6", "cap1 on falling", d, v);
      rd(6, d);  chk("R6", "cap1 flag", d, 32'h0003_0000);

      // R6 capture timing with a running counter
      wr(6, 32'hFFFF_FFFF);
      wr(5, 32'h3);
      wr(0, 1);
      idle(2);
      rd(2, c0);
      cap_in[0] = 1'b0;
      idle(3);
      rd(16, d); chk("R6", "running capture value", d, c0 + 2);
      rd(6, d);  chk("R6", "falling flag in both mode", d, 32'h0001_0000);

      // R7 counting edges of a capture pin
      wr(5, 0);
      for (int mode = 1; mode < 4; mode++) begin
         int n;
         n = 2 + int'($urandom % 6);
         wr(3, 32'h10 | 32'(mode));
         wr(0, 2);
         wr(0, 1);
         pulses(1, n);
         rd(2, d);
         chk("R7", "external edge count", d, 32'((mode == 3) ? 2 * n : n));
      end
      wr(0, 0);
      wr(3, 0);

      // R8, R9 PWM with random period and duty
      for (int r = 0; r < 3; r++) begin
         int per, duty, e;
         per  = 4 + int'($urandom % 9);
         duty = 1 + int'($urandom % per);
         wr(1, 0);
         wr(11, 32'(per));
         wr(8, 32'(duty));
         wr(9, 0);
         wr(10, 32'(per + 1));
         wr(4, 32'h0100_0000);
         wr(0, 2);
         wr(0, 1);
         e = 0;
         for (int t = 0; t < 2 * (per + 1) + 3; t++) begin
            rd(2, d); chk("R8", "pwm count", d, 32'(e));
            chk("R9", "duty output", 32'(match_out[0]), 32'(e >= duty));
            chk("R9", "zero duty high", 32'(match_out[1]), 1);
            chk("R9", "duty above period low", 32'(match_out[2]), 0);
            idle(1);
            e = exp_pwm_next(e, per);
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule